// File: doc/BRIEF.md
# Watchdog Timer with Single or Paired Clear

This block is the watchdog of a small microcontroller core. An 8-bit counter advances by one on each enable tick from an external prescaler. If software fails to restart it before it rolls over from its highest value, the block sets a time-out flag and pulses a one-cycle reset request toward the chip's reset generator. The block also keeps a power-down flag, which a halt strobe sets.

The instruction decoder supplies one-cycle strobes. A mode pin picks how the watchdog is restarted. In single mode, one clear strobe restarts the counter and clears both flags. In paired mode, two distinct preclear strobes, A and B, must both arrive before anything is cleared. They may come in either order or in the same cycle. A lone preclear only latches its own indicator bit. The counter keeps running and both flags keep their values. Every restart returns both indicator bits to 0, so the next restart needs a new pair. All pins are plain level or strobe controls; the block has no data stream.

Top module: `wdt_dual_clear`

## Requirements
- R1: After reset, count_o is 0, to_flag_o is 0, pdf_flag_o is 0, rst_req_o is 0, and both indicator outputs pre_a_o and pre_b_o are 0.
- R2: In a cycle with tick_i high and no restart, count_o increases by 1 at the next clock edge. With tick_i low, count_o holds.
- R3: A tick while count_o is 255 wraps count_o to 0 and sets to_flag_o to 1. rst_req_o is high for exactly the one following cycle.
- R4: With dual_mode_i low (single mode), a clr_single_i strobe sets count_o to 0 and clears to_flag_o and pdf_flag_o at the next edge.
- R5: With dual_mode_i low, preclr_a_i and preclr_b_i have no effect on the counter, the flags or the indicator outputs.
- R6: With dual_mode_i high (paired mode), a lone preclear sets its indicator output (A drives pre_a_o, B drives pre_b_o). The counter keeps counting, and to_flag_o and pdf_flag_o are unchanged.
- R7: In paired mode, once both A and B have been seen (in either order, or in the same cycle), count_o becomes 0, both flags clear, and both indicators return to 0.
- R8: In paired mode, repeating the same preclear strobe never stands in for the other one and causes no restart.
- R9: In paired mode, clr_single_i has no effect.
- R10: halt_i sets pdf_flag_o to 1. If a restart happens in the same cycle, pdf_flag_o still ends at 1.
- R11: A restart takes priority over a tick in the same cycle. count_o ends at 0, and no time-out occurs even when count_o was 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| dual_mode_i | input | 1 | 0 = single clear, 1 = paired preclear |
| clr_single_i | input | 1 | Single clear strobe |
| preclr_a_i | input | 1 | Preclear A strobe |
| preclr_b_i | input | 1 | Preclear B strobe |
| tick_i | input | 1 | Prescaler enable tick |
| halt_i | input | 1 | Halt strobe, sets power-down flag |
| count_o | output | 8 | Current watchdog count |
| to_flag_o | output | 1 | Time-out flag |
| pdf_flag_o | output | 1 | Power-down flag |
| rst_req_o | output | 1 | One-cycle reset request on time-out |
| pre_a_o | output | 1 | Preclear A indicator |
| pre_b_o | output | 1 | Preclear B indicator |

## Verification
The hardest states to reach are those in which a restart meets a counter sitting at 255. Examples are a paired restart completing on the very tick that would otherwise time out, and checking that the time-out flag is cleared afterwards. The bench gets there by holding tick_i high for exactly 255 cycles from a known zero count. It then lines up the second preclear with the next tick. It also lets one full overflow happen, to check that to_flag_o survives lone preclears.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned CNT_W_DEF = 8;

  typedef enum logic {
    CLR_MODE_SINGLE = 1'b0,
    CLR_MODE_PAIRED = 1'b1
  } clr_mode_e;
endpackage

// File: rtl/wdt_clear_arbiter.sv
module wdt_clear_arbiter
  import wdt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  clr_mode_e mode,
  input  logic      clr_single,
  input  logic      pre_a,
  input  logic      pre_b,
  output logic      restart,
  output logic      seen_a_q,
  output logic      seen_b_q
);
  logic paired;
  logic have_a, have_b;

  assign paired = (mode == CLR_MODE_PAIRED);

  // A preclear counts only in paired mode; a held indicator counts as seen
  always_comb begin
    have_a  = seen_a_q | (paired & pre_a);
    have_b  = seen_b_q | (paired & pre_b);
    restart = paired ? (have_a & have_b) : clr_single;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_a_q <= 1'b0;
      seen_b_q <= 1'b0;
    end else if (restart) begin
      seen_a_q <= 1'b0;
      seen_b_q <= 1'b0;
    end else if (paired) begin
      if (pre_a) seen_a_q <= 1'b1;
      if (pre_b) seen_b_q <= 1'b1;
    end
  end

  // R5: indicators never rise in single mode
  assert_single_no_ind_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !paired |=> !$rose(seen_a_q) && !$rose(seen_b_q));
  // R8: a repeated A with no B ever seen leaves A latched and B clear
  assert_repeat_no_swap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    paired && pre_a && !pre_b && !seen_b_q |=> seen_a_q && !seen_b_q);
  // R7: a restart drops both indicators
  assert_restart_drops_ind_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !seen_a_q && !seen_b_q);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  output logic [CNT_W-1:0] count_q,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  assign wrap = tick & ~restart & (count_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count_q <= '0;
    else if (restart) count_q <= '0;
    else if (tick)    count_q <= count_q + 1'b1;
  end

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !restart && count_q != CNT_MAX |=> count_q == $past(count_q) + 1'b1);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !restart |=> $stable(count_q));
  assert_restart_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> count_q == '0);
endmodule

// File: rtl/wdt_flags.sv
module wdt_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic wrap,
  input  logic halt,
  output logic to_q,
  output logic pdf_q,
  output logic rst_req_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_q      <= 1'b0;
      pdf_q     <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= wrap;
      if (restart)   to_q <= 1'b0;
      else if (wrap) to_q <= 1'b1;
      if (halt)         pdf_q <= 1'b1;
      else if (restart) pdf_q <= 1'b0;
    end
  end

  assert_req_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |=> !rst_req_q);
  assert_halt_sets_pdf_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> pdf_q);
  assert_restart_clears_to_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !to_q);
endmodule

// File: rtl/wdt_dual_clear.sv
module wdt_dual_clear
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dual_mode_i,
  input  logic             clr_single_i,
  input  logic             preclr_a_i,
  input  logic             preclr_b_i,
  input  logic             tick_i,
  input  logic             halt_i,
  output logic [CNT_W-1:0] count_o,
  output logic             to_flag_o,
  output logic             pdf_flag_o,
  output logic             rst_req_o,
  output logic             pre_a_o,
  output logic             pre_b_o
);
  clr_mode_e mode;
  logic      restart;
  logic      wrap;

  assign mode = dual_mode_i ? CLR_MODE_PAIRED : CLR_MODE_SINGLE;

  wdt_clear_arbiter u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .clr_single(clr_single_i),
    .pre_a     (preclr_a_i),
    .pre_b     (preclr_b_i),
    .restart   (restart),
    .seen_a_q  (pre_a_o),
    .seen_b_q  (pre_b_o)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_i),
    .restart(restart),
    .count_q(count_o),
    .wrap   (wrap)
  );

  wdt_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .wrap     (wrap),
    .halt     (halt_i),
    .to_q     (to_flag_o),
    .pdf_q    (pdf_flag_o),
    .rst_req_q(rst_req_o)
  );

  // R3: a reset request comes with the time-out flag and a zero count
  assert_req_with_to_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> to_flag_o && count_o == '0);
  // R9: in paired mode a single clear alone leaves the flags alone
  assert_paired_ignores_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dual_mode_i && clr_single_i && !preclr_a_i && !preclr_b_i && !halt_i && !tick_i
    |=> $stable(to_flag_o) && $stable(pdf_flag_o) && $stable(count_o));
endmodule

// File: tb/test_wdt_dual_clear.sv
module test_wdt_dual_clear;
  logic clk = 1'b0, rst_n = 1'b0;
  logic dual_mode_i = 1'b0, clr_single_i = 1'b0, preclr_a_i = 1'b0, preclr_b_i = 1'b0;
  logic tick_i = 1'b0, halt_i = 1'b0;
  logic [7:0] count_o;
  logic to_flag_o, pdf_flag_o, rst_req_o, pre_a_o, pre_b_o;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  wdt_dual_clear i_wdt_dual_clear (.*);

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    clr_single_i = 0; preclr_a_i = 0; preclr_b_i = 0; tick_i = 0; halt_i = 0;
  endtask

  // one cycle with current inputs, then inputs go idle; outputs readable after
  task automatic cyc();
    @(negedge clk);
    idle();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin tick_i = 1; cyc(); end
  endtask

  task automatic do_reset();
    idle(); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 count", count_o, 0);
    chk("R1 to", to_flag_o, 0);
    chk("R1 pdf", pdf_flag_o, 0);
    chk("R1 req", rst_req_o, 0);
    chk("R1 ind", {pre_a_o, pre_b_o}, 0);
  endtask

  task automatic t_count();
    do_reset();
    ticks(5);
    chk("R2 count after 5", count_o, 5);
    cyc(); cyc();
    chk("R2 hold", count_o, 5);
  endtask

  task automatic t_overflow();
    do_reset();
    ticks(255);
    chk("R3 at max", count_o, 255);
    chk("R3 no to yet", to_flag_o, 0);
    tick_i = 1; cyc();
    chk("R3 wrap", count_o, 0);
    chk("R3 to", to_flag_o, 1);
    chk("R3 req", rst_req_o, 1);
    cyc();
    chk("R3 req one cycle", rst_req_o, 0);
    chk("R3 to held", to_flag_o, 1);
  endtask

  task automatic t_single();
    do_reset(); dual_mode_i = 0;
    ticks(255); tick_i = 1; cyc();
    halt_i = 1; ticks(3);
    chk("R10 pdf", pdf_flag_o, 1);
    preclr_a_i = 1; cyc();
    preclr_b_i = 1; cyc();
    chk("R5 count", count_o, 3);
    chk("R5 ind", {pre_a_o, pre_b_o}, 0);
    chk("R5 to", to_flag_o, 1);
    clr_single_i = 1; cyc();
    chk("R4 count", count_o, 0);
    chk("R4 to", to_flag_o, 0);
    chk("R4 pdf", pdf_flag_o, 0);
  endtask

  task automatic t_paired();
    do_reset(); dual_mode_i = 1;
    ticks(255); tick_i = 1; cyc();   // time-out, count 0
    halt_i = 1; cyc();
    ticks(4);
    preclr_b_i = 1; tick_i = 1; cyc();
    chk("R6 ind b", {pre_a_o, pre_b_o}, 1);
    chk("R6 count runs", count_o, 5);
    chk("R6 to kept", to_flag_o, 1);
    chk("R6 pdf kept", pdf_flag_o, 1);
    preclr_b_i = 1; cyc();
    chk("R8 repeat b no restart", count_o, 5);
    clr_single_i = 1; cyc();
    chk("R9 single ignored", count_o, 5);
    chk("R9 to kept", to_flag_o, 1);
    preclr_a_i = 1; cyc();
    chk("R7 b then a count", count_o, 0);
    chk("R7 to", to_flag_o, 0);
    chk("R7 pdf", pdf_flag_o, 0);
    chk("R7 ind", {pre_a_o, pre_b_o}, 0);
    ticks(3);
    preclr_a_i = 1; cyc();
    chk("R6 ind a", {pre_a_o, pre_b_o}, 2);
    preclr_a_i = 1; cyc();
    chk("R8 repeat a", count_o, 3);
    preclr_b_i = 1; cyc();
    chk("R7 a then b", count_o, 0);
    ticks(2);
    preclr_a_i = 1; preclr_b_i = 1; cyc();
    chk("R7 same cycle", count_o, 0);
    chk("R7 same cycle ind", {pre_a_o, pre_b_o}, 0);
  endtask

  task automatic t_priority();
    do_reset(); dual_mode_i = 1;
    ticks(255);
    preclr_a_i = 1; cyc();
    preclr_b_i = 1; tick_i = 1; halt_i = 1; cyc();
    chk("R11 count", count_o, 0);
    chk("R11 no to", to_flag_o, 0);
    chk("R11 no req", rst_req_o, 0);
    chk("R10 halt beats restart", pdf_flag_o, 1);
  endtask

  initial begin
    #(2_000_000);
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_count();
    t_overflow();
    t_single();
    t_paired();
    t_priority();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule